// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM with a shared data path. Every rising clock edge registers the command, the address, the extra address pin and the byte enables. A read command places its word on the output one full cycle later. A write command is followed one cycle later by its data. That data is held in a one-deep write buffer and moves into the array only when the next write's data arrives. Reads that hit the buffered address see the buffered bytes lane by lane, so the late write stays invisible to the user.

A static mode input sets how the extra address pin `xa` is used. In conventional mode, `xa` is the most significant address bit and is sampled with every command. In late-select mode, the array is treated as two banks chosen by `xa`. A write samples the bank with its command. A read samples the bank one edge later, on the same edge that loads the output register. The bidirectional data bus is presented as separate `dq_in` and `dq_out` paths plus a drive enable `dq_drive`. The pad ring combines them into one bus. An active-low output enable gates `dq_drive` without passing through a register.

Top module: `lw_sram`

## Requirements
- R1: Command decode at the clock edge. `cs_n`=1 is a deselect, whatever `we_n` is, and writes nothing. `cs_n`=0 with `we_n`=1 is a read. `cs_n`=0 with `we_n`=0 is a write.
- R2: For a read registered at edge t, `dq_out` carries the addressed word and `dq_drive` is 1 from edge t+1 until edge t+2, provided `oe_n`=0.
- R3: For a write registered at edge t, the data is taken from `dq_in` at edge t+1. Address, bank and byte enables are the ones sampled at edge t.
- R4: `bw_n[i]`=0 enables byte lane i, which is bits [9i+8:9i] of the data word. Lanes whose enable is 1 keep their old contents.
- R5: A write with `bw_n`=4'b1111 is an abort. It changes neither the array nor the word held in the write buffer.
- R6: With `mode_conv`=0 (late select), a write uses the `xa` value sampled with its command. A read uses the `xa` value sampled one edge after its command as the bank bit.
- R7: With `mode_conv`=1 (conventional), a read uses the `xa` value sampled with its command as address bit ADDR_W-1. The `xa` value on the following edge has no effect.
- R8: A read whose address matches the buffered write returns the buffered data in the lanes that write enabled, and array data in the other lanes. This holds even when the read is issued in the cycle where that write's data arrives.
- R9: `oe_n`=1 forces `dq_drive` to 0 at once, with no clock edge. Returning `oe_n` to 0 restores the pending read data.
- R10: `dq_drive` is 0 after reset, and it is 0 in the cycle after a deselect or a write command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_conv | input | 1 | 1 = conventional mode, 0 = late-select (two-bank) mode |
| cs_n | input | 1 | Active-low select |
| we_n | input | 1 | Active-low write enable |
| bw_n | input | 4 | Active-low byte write enables, one per 9-bit lane |
| addr | input | ADDR_W-1 | Word address within a bank |
| xa | input | 1 | Extra address bit or late bank select |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_in | input | 36 | Write data from the bus |
| dq_out | output | 36 | Read data to the bus (zero when not driving) |
| dq_drive | output | 1 | Bus drive enable for dq_out |

## Verification
A read issued before edge t must show its data on the output after edge t+1. A write's data must be supplied in the cycle after its command. The late-select bank is whatever `xa` holds during that following cycle. The bench drives inputs on falling edges and steps one rising edge per command. It samples the output at the falling edge that follows the second rising edge after a read. For `oe_n`, it checks a moment after the level change with no clock edge in between. The cases covered are back-to-back write and read to the same address, abort after a write, and a read followed directly by a write. Each has its result counted to that same edge.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/lw_sram_cmd.sv
module lw_sram_cmd
  import lw_sram_pkg::*;
#(
  parameter int PIN_AW = 7,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [PIN_AW-1:0] addr,
  input  logic              xa,
  output op_e               op_q,
  output logic [PIN_AW-1:0] addr_q,
  output logic              xa_q,
  output logic [LANES-1:0]  be_q
);
  op_e op_d;
  logic take;

  always_comb begin
    take = !cs_n;
    if (cs_n)      op_d = OP_IDLE;
    else if (we_n) op_d = OP_RD;
    else           op_d = OP_WR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      xa_q   <= 1'b0;
      be_q   <= '0;
    end else begin
      op_q <= op_d;
      if (take) begin
        addr_q <= addr;
        xa_q   <= xa;
        be_q   <= ~bw_n;
      end
    end
  end

  // R1: a deselect at the edge leaves no operation pending
  a_r1_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (op_q == OP_IDLE));
  // R1: select with write enable low becomes a write
  a_r1_write_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |=> (op_q == OP_WR));
endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int IDX_W  = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [IDX_W-1:0]        waddr,
  input  logic [LANES-1:0]        wbe,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [IDX_W-1:0]        raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    logic              lane_we;

    always_comb lane_we = we && wbe[g];

    always_ff @(posedge clk) begin
      if (lane_we) lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = lane_mem[raddr];
  end
endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf #(
  parameter int IDX_W  = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [IDX_W-1:0]        load_addr,
  input  logic [LANES-1:0]        load_be,
  input  logic [LANES*LANE_W-1:0] load_data,
  input  logic [IDX_W-1:0]        raddr,
  input  logic [LANES*LANE_W-1:0] arr_rdata,
  output logic [LANES*LANE_W-1:0] merged,
  output logic                    commit_we,
  output logic [IDX_W-1:0]        commit_addr,
  output logic [LANES-1:0]        commit_be,
  output logic [LANES*LANE_W-1:0] commit_data
);
  logic                    wb_valid;
  logic [IDX_W-1:0]        wb_addr;
  logic [LANES-1:0]        wb_be;
  logic [LANES*LANE_W-1:0] wb_data;
  logic                    hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_addr  <= '0;
      wb_be    <= '0;
      wb_data  <= '0;
    end else if (load) begin
      wb_valid <= 1'b1;
      wb_addr  <= load_addr;
      wb_be    <= load_be;
      wb_data  <= load_data;
    end
  end

  always_comb begin
    commit_we   = load && wb_valid;
    commit_addr = wb_addr;
    commit_be   = wb_be;
    commit_data = wb_data;
    hit         = wb_valid && (wb_addr == raddr);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g*LANE_W +: LANE_W] = (hit && wb_be[g]) ?
      wb_data[g*LANE_W +: LANE_W] : arr_rdata[g*LANE_W +: LANE_W];
  end

  // R5: without a load the buffered write is untouched
  a_r5_buffer_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(wb_valid) && $stable(wb_addr) && $stable(wb_data) && $stable(wb_be)));
  // R3: a load captures the data presented on that edge
  a_r3_data_taken: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (wb_valid && wb_data == $past(load_data) && wb_addr == $past(load_addr)));
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_conv,
  input  logic                    cs_n,
  input  logic                    we_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic [ADDR_W-2:0]       addr,
  input  logic                    xa,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_drive
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int PIN_AW = ADDR_W - 1;

  op_e               op_q;
  logic [PIN_AW-1:0] addr_q;
  logic              xa_q;
  logic [LANES-1:0]  be_q;

  logic              rd_bank;
  logic [ADDR_W-1:0] rd_idx;
  logic [ADDR_W-1:0] wr_idx;
  logic              buf_load;
  logic [DATA_W-1:0] arr_rdata;
  logic [DATA_W-1:0] merged;
  logic              commit_we;
  logic [ADDR_W-1:0] commit_addr;
  logic [LANES-1:0]  commit_be;
  logic [DATA_W-1:0] commit_data;

  logic [DATA_W-1:0] dout_q;
  logic              rd_act_q;
  logic              dout_en;

  lw_sram_cmd #(.PIN_AW(PIN_AW), .LANES(LANES)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .bw_n(bw_n),
    .addr(addr), .xa(xa), .op_q(op_q), .addr_q(addr_q), .xa_q(xa_q), .be_q(be_q)
  );

  always_comb begin
    rd_bank  = mode_conv ? xa_q : xa;
    rd_idx   = {rd_bank, addr_q};
    wr_idx   = {xa_q, addr_q};
    buf_load = (op_q == OP_WR) && (|be_q);
    dout_en  = (op_q == OP_RD);
  end

  lw_sram_wbuf #(.IDX_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .load(buf_load), .load_addr(wr_idx),
    .load_be(be_q), .load_data(dq_in), .raddr(rd_idx), .arr_rdata(arr_rdata),
    .merged(merged), .commit_we(commit_we), .commit_addr(commit_addr),
    .commit_be(commit_be), .commit_data(commit_data)
  );

  lw_sram_array #(.IDX_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .we(commit_we), .waddr(commit_addr), .wbe(commit_be),
    .wdata(commit_data), .raddr(rd_idx), .rdata(arr_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q   <= '0;
      rd_act_q <= 1'b0;
    end else begin
      rd_act_q <= dout_en;
      if (dout_en) dout_q <= merged;
    end
  end

  always_comb begin
    dq_drive = rd_act_q && !oe_n;
    dq_out   = dq_drive ? dout_q : '0;
  end

  // R10: no drive in the cycle after a deselect or a write
  a_r10_float_after_nonread: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q != OP_RD) |=> !dq_drive);
endmodule

// File: tb/sim_lw_sram.sv
module sim_lw_sram;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_conv;
  logic        cs_n, we_n, xa, oe_n;
  logic [3:0]  bw_n;
  logic [6:0]  addr;
  logic [35:0] dq_in;
  logic [35:0] dq_out;
  logic        dq_drive;
  int          n_chk = 0;
  int          n_err = 0;

  lw_sram u0 (
    .clk(clk), .rst_n(rst_n), .mode_conv(mode_conv), .cs_n(cs_n), .we_n(we_n),
    .bw_n(bw_n), .addr(addr), .xa(xa), .oe_n(oe_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_drive(dq_drive)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [36:0] act, input logic [36:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R4: lane i = bits [9i+8:9i], written when bw_n[i]==0
  function automatic logic [35:0] lanes(input logic [35:0] old, input logic [35:0] nw, input logic [3:0] b);
    logic [35:0] r = old;
    for (int i = 0; i < 4; i++) if (!b[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  task automatic step(input logic c, input logic w, input logic [3:0] b,
                      input logic [6:0] a, input logic x, input logic [35:0] d);
    cs_n = c; we_n = w; bw_n = b; addr = a; xa = x; dq_in = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic x, input logic [3:0] b, input logic [35:0] d);
    step(0, 0, b, a, x, '0);
    step(1, 1, 4'hF, '0, 0, d);
  endtask

  task automatic rd_chk(input logic [6:0] a, input logic xc, input logic xl,
                        input logic [35:0] exp, input string tag);
    step(0, 1, 4'hF, a, xc, '0);
    step(1, 1, 4'hF, '0, xl, '0);
    chk(dq_drive === 1'b1 && dq_out === exp, tag, {dq_drive, dq_out}, {1'b1, exp});
  endtask

  task automatic t_reset();
    chk(dq_drive === 1'b0, "R10 reset no drive", {36'd0, dq_drive}, 37'd0);
  endtask

  task automatic t_basic();
    mode_conv = 1;
    wr(7'd10, 0, 4'h0, 36'h1_2345_6789);
    wr(7'd11, 0, 4'h0, 36'hA_BCDE_F012);
    wr(7'd12, 1, 4'h0, 36'h5_5555_5555);
    rd_chk(7'd10, 0, 0, 36'h1_2345_6789, "R2 R3 read array word");
    rd_chk(7'd11, 0, 1, 36'hA_BCDE_F012, "R2 R7 read second word");
    rd_chk(7'd12, 1, 0, 36'h5_5555_5555, "R1 R7 read buffered xa=1");
  endtask

  task automatic t_bytes();
    mode_conv = 1;
    wr(7'd20, 0, 4'h0, 36'h1_1111_1111);
    wr(7'd20, 0, 4'b1010, 36'hF_EDCB_A987);
    rd_chk(7'd20, 0, 0, lanes(36'h1_1111_1111, 36'hF_EDCB_A987, 4'b1010), "R4 R8 partial in buffer");
    wr(7'd21, 0, 4'h0, 36'h0_0000_0001);
    rd_chk(7'd20, 0, 0, lanes(36'h1_1111_1111, 36'hF_EDCB_A987, 4'b1010), "R4 partial after commit");
  endtask

  task automatic t_coherent();
    mode_conv = 1;
    wr(7'd30, 0, 4'h0, 36'h3_3333_3333);
    wr(7'd31, 0, 4'h0, 36'h0_0000_0000);
    step(0, 0, 4'b0110, 7'd30, 0, '0);
    step(0, 1, 4'hF, 7'd30, 0, 36'hC_CCCC_CCCC);
    step(1, 1, 4'hF, '0, 0, '0);
    chk(dq_drive === 1'b1 && dq_out === lanes(36'h3_3333_3333, 36'hC_CCCC_CCCC, 4'b0110),
        "R8 back-to-back write then read merge", {dq_drive, dq_out},
        {1'b1, lanes(36'h3_3333_3333, 36'hC_CCCC_CCCC, 4'b0110)});
  endtask

  task automatic t_abort();
    mode_conv = 1;
    wr(7'd40, 0, 4'h0, 36'h4_0404_0404);
    wr(7'd41, 0, 4'h0, 36'h4_1414_1414);
    wr(7'd40, 0, 4'hF, 36'hD_EADD_EADD);
    rd_chk(7'd40, 0, 0, 36'h4_0404_0404, "R5 abort leaves array");
    rd_chk(7'd41, 0, 0, 36'h4_1414_1414, "R5 abort keeps buffer");
    step(1, 0, 4'h0, 7'd40, 0, '0);
    step(1, 1, 4'hF, '0, 0, 36'hB_ADBA_DBAD);
    rd_chk(7'd40, 0, 0, 36'h4_0404_0404, "R1 deselect with we_n low writes nothing");
  endtask

  task automatic t_late_sel();
    mode_conv = 0;
    wr(7'd5, 0, 4'h0, 36'h0_AAAA_0000);
    wr(7'd5, 1, 4'h0, 36'h1_BBBB_1111);
    rd_chk(7'd5, 1, 0, 36'h0_AAAA_0000, "R6 late bank 0 ignores cmd xa");
    rd_chk(7'd5, 0, 1, 36'h1_BBBB_1111, "R6 late bank 1");
    mode_conv = 1;
    rd_chk(7'd5, 1, 0, 36'h1_BBBB_1111, "R7 conventional xa with command");
    rd_chk(7'd5, 0, 1, 36'h0_AAAA_0000, "R7 conventional ignores late xa");
  endtask

  task automatic t_oe();
    mode_conv = 1;
    step(0, 1, 4'hF, 7'd10, 0, '0);
    step(1, 1, 4'hF, '0, 0, '0);
    oe_n = 1; #0.5;
    chk(dq_drive === 1'b0, "R9 oe_n high floats at once", {36'd0, dq_drive}, 37'd0);
    oe_n = 0; #0.5;
    chk(dq_drive === 1'b1 && dq_out === 36'h1_2345_6789, "R9 oe_n low restores",
        {dq_drive, dq_out}, {1'b1, 36'h1_2345_6789});
    step(1, 1, 4'hF, '0, 0, '0);
    chk(dq_drive === 1'b0, "R10 float after deselect", {36'd0, dq_drive}, 37'd0);
    step(0, 1, 4'hF, 7'd11, 0, '0);
    step(0, 0, 4'h0, 7'd50, 0, '0);
    chk(dq_drive === 1'b1 && dq_out === 36'hA_BCDE_F012, "R2 read before write",
        {dq_drive, dq_out}, {1'b1, 36'hA_BCDE_F012});
    step(1, 1, 4'hF, '0, 0, 36'h7_7777_7777);
    chk(dq_drive === 1'b0, "R10 float after write", {36'd0, dq_drive}, 37'd0);
    rd_chk(7'd50, 0, 0, 36'h7_7777_7777, "R3 data one cycle after command");
  endtask

  initial begin
    #(4 * 20000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; mode_conv = 1; cs_n = 1; we_n = 1; bw_n = 4'hF;
    addr = '0; xa = 0; oe_n = 0; dq_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_bytes();
    t_coherent();
    t_abort();
    t_late_sel();
    t_oe();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule